// File: doc/BRIEF.md
# Even/Odd Black-Level Clamp

This block sits after the converter that digitizes a linear image sensor's output. Each sample comes in with a tag and a position index from the readout sequencer. Shielded reference positions carry the dark level of the two interleaved output channels. The block averages one fixed set of shielded positions for even channel samples and another for odd ones. It then subtracts the matching level from every active pixel. The result never drops below zero.

A line starts with reference position 0. The shielded window lies at reference positions 24 to 53, and both averages are final before the first active pixel arrives. Corrected active pixels leave one cycle after they enter, and a flag marks the last pixel of the line. A freeze input keeps the levels measured on an earlier line in place of the new measurement.

Top module: `clampTop`

## Requirements
- R1: The even level is the average of reference positions 24, 26, ... 52 (15 samples), rounded to the nearest integer.
- R2: The odd level is the average of reference positions 25, 27, ... 53 (15 samples), rounded to the nearest integer.
- R3: Samples at reference positions outside 24..53 do not affect either level.
- R4: Active pixel k (index 1..3000, tag 2) leaves as its data minus the even level when k is even, or minus the odd level when k is odd.
- R5: When the level exceeds the pixel data, the output is 0 and does not wrap.
- R6: `outVld` is high exactly one cycle after an accepted active sample (inVld high, tag 2), and low otherwise. Tag 0 is idle, tag 1 is a reference position, and tag 3 is ignored.
- R7: `outEol` is high together with the output of active pixel 3000 and at no other time.
- R8: Both accumulators clear when reference position 0 arrives, so each line's levels depend only on that line.
- R9: When `freeze` is high in the cycle after reference position 53, both levels keep their previous values.
- R10: After reset both levels are 0 and `outVld` is low, so active pixels pass unchanged until a line has been measured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inVld | input | 1 | Input sample valid |
| inTag | input | 2 | 0 idle, 1 reference position, 2 active pixel, 3 ignored |
| inIndex | input | IDX_W | Reference position number or active pixel number |
| inData | input | DATA_W | Digitized sample |
| freeze | input | 1 | Hold the previous line's levels |
| outVld | output | 1 | Corrected pixel valid |
| outData | output | DATA_W | Corrected pixel |
| outEol | output | 1 | Last active pixel of the line |

## Verification
The hardest cases are the rounding boundary and the case where stale sums would carry over between lines. Both levels are visible only indirectly, through thousands of corrected pixels. The bench therefore feeds reference windows whose sums leave remainders of 7 and 8 on either side of the half-way point. All out-of-window reference positions carry full-scale data. Consecutive lines use different windows, with freeze set on one line and clear on the next, so a stale, leaked or unfrozen level changes the expected value of every active pixel.

// File: rtl/clampPkg.sv
package clampPkg;
  typedef enum logic [1:0] {
    TAG_IDLE = 2'd0,
    TAG_REF  = 2'd1,
    TAG_ACT  = 2'd2,
    TAG_RSVD = 2'd3
  } tag_e;

  typedef struct packed {
    logic clrAcc;
    logic addEven;
    logic addOdd;
    logic commit;
    logic emit;
    logic useOdd;
    logic eol;
  } ctrl_t;
endpackage

// File: rtl/clampCtrl.sv
module clampCtrl
  import clampPkg::*;
#(
  parameter int IDX_W        = 12,
  parameter int REF_FIRST    = 24,
  parameter int REF_COUNT    = 15,
  parameter int ACTIVE_COUNT = 3000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inVld,
  input  tag_e             inTag,
  input  logic [IDX_W-1:0] inIndex,
  input  logic             freeze,
  output ctrl_t            ctrl
);
  localparam int REF_LAST = REF_FIRST + 2 * REF_COUNT - 1;
  localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(REF_FIRST);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(REF_LAST);
  localparam logic [IDX_W-1:0] EOL_IDX   = IDX_W'(ACTIVE_COUNT);

  logic isRef, isAct, inWindow, commitPend;

  always_comb begin
    isRef    = inVld && (inTag == TAG_REF);
    isAct    = inVld && (inTag == TAG_ACT);
    inWindow = isRef && (inIndex >= FIRST_IDX) && (inIndex <= LAST_IDX);
    ctrl.clrAcc  = isRef && (inIndex == '0);
    ctrl.addEven = inWindow && !inIndex[0];
    ctrl.addOdd  = inWindow && inIndex[0];
    ctrl.commit  = commitPend && !freeze;
    ctrl.emit    = isAct;
    ctrl.useOdd  = inIndex[0];
    ctrl.eol     = isAct && (inIndex == EOL_IDX);
  end

  // Level update one cycle after the last window sample lands in its sum
  always_ff @(posedge clk) begin
    if (!rstN) commitPend <= 1'b0;
    else       commitPend <= isRef && (inIndex == LAST_IDX);
  end
endmodule

// File: rtl/clampDatapath.sv
module clampDatapath
  import clampPkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int REF_COUNT = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] inData,
  output logic              outVld,
  output logic [DATA_W-1:0] outData,
  output logic              outEol
);
  localparam int SUM_W  = DATA_W + $clog2(REF_COUNT);
  localparam int SHIFT  = SUM_W + $clog2(REF_COUNT) + 1;
  localparam longint RECIP = ((64'd1 << SHIFT) + REF_COUNT - 1) / REF_COUNT;
  localparam int HALF   = REF_COUNT / 2;

  logic [SUM_W-1:0]  accEven, accOdd;
  logic [DATA_W-1:0] blackEven, blackOdd;
  logic [DATA_W-1:0] levelEven, levelOdd, selLevel;
  logic [63:0]       prodEven, prodOdd;

  // Round-to-nearest divide by a fixed-point reciprocal multiply
  always_comb begin
    prodEven  = (64'(accEven) + 64'(HALF)) * 64'(RECIP);
    prodOdd   = (64'(accOdd) + 64'(HALF)) * 64'(RECIP);
    levelEven = prodEven[SHIFT +: DATA_W];
    levelOdd  = prodOdd[SHIFT +: DATA_W];
    selLevel  = ctrl.useOdd ? blackOdd : blackEven;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accEven <= '0;
      accOdd  <= '0;
    end else if (ctrl.clrAcc) begin
      accEven <= '0;
      accOdd  <= '0;
    end else begin
      if (ctrl.addEven) accEven <= accEven + SUM_W'(inData);
      if (ctrl.addOdd)  accOdd  <= accOdd + SUM_W'(inData);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blackEven <= '0;
      blackOdd  <= '0;
    end else if (ctrl.commit) begin
      blackEven <= levelEven;
      blackOdd  <= levelOdd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outVld  <= 1'b0;
      outEol  <= 1'b0;
      outData <= '0;
    end else begin
      outVld <= ctrl.emit;
      outEol <= ctrl.eol;
      if (ctrl.emit) outData <= (inData > selLevel) ? (inData - selLevel) : '0;
    end
  end
endmodule

// File: rtl/clampTop.sv
module clampTop
  import clampPkg::*;
#(
  parameter int DATA_W       = 12,
  parameter int IDX_W        = 12,
  parameter int REF_FIRST    = 24,
  parameter int REF_COUNT    = 15,
  parameter int ACTIVE_COUNT = 3000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inVld,
  input  logic [1:0]        inTag,
  input  logic [IDX_W-1:0]  inIndex,
  input  logic [DATA_W-1:0] inData,
  input  logic              freeze,
  output logic              outVld,
  output logic [DATA_W-1:0] outData,
  output logic              outEol
);
  ctrl_t ctrl;

  clampCtrl #(
    .IDX_W(IDX_W), .REF_FIRST(REF_FIRST),
    .REF_COUNT(REF_COUNT), .ACTIVE_COUNT(ACTIVE_COUNT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .inVld(inVld), .inTag(tag_e'(inTag)),
    .inIndex(inIndex), .freeze(freeze), .ctrl(ctrl)
  );

  clampDatapath #(
    .DATA_W(DATA_W), .REF_COUNT(REF_COUNT)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .inData(inData),
    .outVld(outVld), .outData(outData), .outEol(outEol)
  );
endmodule

// File: rtl/clampChecks.sv
module clampChecks #(
  parameter int DATA_W       = 12,
  parameter int IDX_W        = 12,
  parameter int ACTIVE_COUNT = 3000
) (
  input logic              clk,
  input logic              rstN,
  input logic              inVld,
  input logic [1:0]        inTag,
  input logic [IDX_W-1:0]  inIndex,
  input logic [DATA_W-1:0] inData,
  input logic              outVld,
  input logic [DATA_W-1:0] outData,
  input logic              outEol
);
  a_r6_vld_after_active: assert property (@(posedge clk) disable iff (!rstN)
    (inVld && inTag == 2'd2) |=> outVld);
  a_r6_quiet_otherwise: assert property (@(posedge clk) disable iff (!rstN)
    !(inVld && inTag == 2'd2) |=> !outVld);
  a_r7_eol_on_last: assert property (@(posedge clk) disable iff (!rstN)
    (inVld && inTag == 2'd2 && inIndex == IDX_W'(ACTIVE_COUNT)) |=> outEol);
  a_r7_eol_only_with_vld: assert property (@(posedge clk) disable iff (!rstN)
    outEol |-> outVld);
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (inVld && inTag == 2'd2) |=> (outData <= $past(inData)));
endmodule

bind clampTop clampChecks #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .ACTIVE_COUNT(ACTIVE_COUNT)
) uChecks (
  .clk(clk), .rstN(rstN), .inVld(inVld), .inTag(inTag), .inIndex(inIndex),
  .inData(inData), .outVld(outVld), .outData(outData), .outEol(outEol)
);

// File: tb/tb_clampTop.sv
module tb_clampTop;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int IW = 12;
  localparam int NACT = 3000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inVld = 1'b0;
  logic [1:0] inTag = 2'd0;
  logic [IW-1:0] inIndex = '0;
  logic [DW-1:0] inData = '0;
  logic freeze = 1'b0;
  logic outVld, outEol;
  logic [DW-1:0] outData;

  int nTests = 0;
  int nFails = 0;
  int curEven = 0;
  int curOdd = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clampTop dut (
    .clk(clk), .rstN(rstN), .inVld(inVld), .inTag(inTag), .inIndex(inIndex),
    .inData(inData), .freeze(freeze), .outVld(outVld), .outData(outData),
    .outEol(outEol)
  );

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one sample at a falling edge, check its result at the next falling edge
  task automatic put(input int tag, input int idx, input int data,
                     input bit expVld, input int expData, input bit expEol,
                     input string dataReq);
    inVld = (tag != 0);
    inTag = 2'(tag);
    inIndex = IW'(idx);
    inData = DW'(data);
    @(negedge clk);
    check("R6 outVld", int'(outVld), int'(expVld));
    check("R7 outEol", int'(outEol), int'(expEol));
    if (expVld) check(dataReq, int'(outData), expData);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 outVld in reset", int'(outVld), 0);
    check("R10 outEol in reset", int'(outEol), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 outVld after reset", int'(outVld), 0);
  endtask

  // Levels are zero until the first measured line: data passes unchanged
  task automatic testNoReference();
    for (int k = 1; k <= 6; k++) put(2, k, 100 + k, 1'b1, 100 + k, 1'b0, "R10 pass-through");
    put(3, 5, 77, 1'b0, 0, 1'b0, "R6 tag 3");
    put(0, 0, 0, 1'b0, 0, 1'b0, "R6 idle");
  endtask

  // One full line; window sums are base*15 + bump, the rest of the references are full scale
  task automatic runLine(input int eBase, input int eBump, input int oBase, input int oBump,
                         input bit frz, input int seed, input string lineReq);
    freeze = frz;
    if (!frz) begin
      curEven = (15 * eBase + eBump + 7) / 15;
      curOdd  = (15 * oBase + oBump + 7) / 15;
    end
    for (int d = 0; d <= 55; d++) begin
      int v;
      if (d >= 24 && d <= 53) begin
        if (d % 2 == 0) v = eBase + ((d == 24) ? eBump : 0);
        else            v = oBase + ((d == 25) ? oBump : 0);
      end else v = 4095; // R3: outside the window
      put(1, d, v, 1'b0, 0, 1'b0, lineReq);
    end
    for (int k = 1; k <= NACT; k++) begin
      int v, lvl, e;
      v = (k * 37 + seed) % 4096;
      lvl = (k % 2 == 0) ? curEven : curOdd;
      e = (v > lvl) ? v - lvl : 0;
      put(2, k, v, 1'b1, e, (k == NACT),
          (e == 0) ? {lineReq, " R5 saturate"} : {lineReq, " R4 subtract"});
    end
    for (int d = 56; d <= 65; d++) put(1, d, 4095, 1'b0, 0, 1'b0, {lineReq, " R3"});
    put(0, 0, 4095, 1'b0, 0, 1'b0, "R6 idle");
    put(0, 0, 4095, 1'b0, 0, 1'b0, "R6 idle");
    freeze = 1'b0;
  endtask

  task automatic testBasicLevels();
    runLine(100, 0, 200, 7, 1'b0, 11, "R1 R2 R3");        // levels 100 / 200 (200.47 rounds down)
  endtask

  task automatic testRoundingAndClamp();
    runLine(10, 8, 4095, 0, 1'b0, 900, "R1 rounding R2 full scale");  // 10.53 -> 11, odd 4095
  endtask

  task automatic testFreeze();
    runLine(500, 0, 500, 0, 1'b1, 4000, "R9 freeze");     // levels stay 11 / 4095
  endtask

  task automatic testLineClear();
    runLine(0, 14, 3, 0, 1'b0, 7, "R8 clear R1");         // 0.93 -> 1, odd 3
  endtask

  initial begin
    testReset();
    testNoReference();
    testBasicLevels();
    testRoundingAndClamp();
    testFreeze();
    testLineClear();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      nTests++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end
endmodule